// File: doc/BRIEF.md
# Threshold-Watching Data Buffer with DMA Requests

This block is a 32-entry by 16-bit circular data buffer placed between a host register port and a card data engine. Either side may push words in or pop words out. The buffer keeps a head index and a fill count. It compares the fill count against two programmable thresholds and either asks a DMA engine for service or raises a status flag that software can poll.

The direction of the current transfer decides which threshold matters. When data flows from the card to the host, the block watches for the buffer getting too full. When data flows from the host to the card, it watches for the buffer running low. A per-direction DMA enable in the configuration word decides whether a crossed threshold drives a DMA request line or a polled flag. The two flags feed a shared interrupt status register elsewhere in the host.

Top module: `dbuf_thresh_fifo`

## Requirements
- R1: After reset the buffer is empty, the almost-full level is 31, the almost-empty level is 0, and both DMA enables are off. All requests and flags are low.
- R2: Words leave the buffer in the order they entered. The storage wraps around 32 slots, and the fill level never exceeds 32.
- R3: A push while the buffer holds 32 words is discarded, and the level stays at 32.
- R4: A pop while the buffer is empty moves nothing. The level stays at 0, and the read data keeps showing the word in the slot at the head index.
- R5: `host_rdata` and `eng_rdata` both show the word at the head of the buffer at all times.
- R6: When `xfer_dir`=1 (card to host), a fill level strictly above the almost-full level does one of two things. With receive DMA enabled it drives `rx_dma_req`; otherwise it drives `flag_af`. When the condition is false, both are low.
- R7: When `xfer_dir`=0 (host to card), a fill level strictly below the almost-empty level does one of two things. With transmit DMA enabled it drives `tx_dma_req`; otherwise it drives `flag_ae`. When the condition is false, both are low.
- R8: When `xfer_active`=0 and the buffer is empty, all four of `rx_dma_req`, `tx_dma_req`, `flag_af` and `flag_ae` are low. When `xfer_active`=0 and the buffer is not empty, the thresholds are still evaluated for `xfer_dir`.
- R9: The configuration word is laid out as follows: bit 15 is the receive DMA enable, bits 12:8 the almost-full level, bit 7 the transmit DMA enable, and bits 4:0 the almost-empty level. All other bits are ignored.
- R10: Writing the configuration word with a DMA enable set clears the matching status flag from the next cycle on.
- R11: `flush` empties the buffer and returns the head index to slot 0. A push or pop in the same cycle is ignored.
- R12: When both sides push in one cycle, only the host word is stored. A push and a pop in the same cycle on a buffer that is neither empty nor full leave the level unchanged.
- R13: The level, requests and flags reflect a push, pop or configuration write from the cycle after it. The transfer direction and active inputs act within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the buffer and rewind the head index |
| xfer_active | input | 1 | A data transfer is in progress |
| xfer_dir | input | 1 | 1 = card to host, 0 = host to card |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 16 | Configuration word (layout in R9) |
| host_push | input | 1 | Host writes one word |
| host_wdata | input | 16 | Host write word |
| host_pop | input | 1 | Host consumes the head word |
| host_rdata | output | 16 | Head word, host view |
| eng_push | input | 1 | Engine writes one word |
| eng_wdata | input | 16 | Engine write word |
| eng_pop | input | 1 | Engine consumes the head word |
| eng_rdata | output | 16 | Head word, engine view |
| fill_level | output | 6 | Number of words held, 0 to 32 |
| rx_dma_req | output | 1 | Receive DMA service request |
| tx_dma_req | output | 1 | Transmit DMA service request |
| flag_af | output | 1 | Almost-full status flag, polled mode |
| flag_ae | output | 1 | Almost-empty status flag, polled mode |

## Verification
The bench fills the buffer to 32 and pushes once more. A design that let the extra word in would wrap its index and corrupt the oldest data. It pops an empty buffer after the head has wrapped, which exposes any design that moves its index or shows a different slot. It toggles the DMA enables with a threshold already crossed: a design that kept the flag latched, or that asserted request and flag together, would show both active. A long pseudo-random phase mixes flushes, direction changes, simultaneous pushes and push-with-pop, which catches a wrong source priority or off-by-one threshold comparisons.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

    localparam int WORD_W     = 16;
    localparam int LVL_W      = 5;
    localparam int RX_EN_BIT  = 15;
    localparam int AF_LSB     = 8;
    localparam int TX_EN_BIT  = 7;
    localparam int AE_LSB     = 0;

    typedef struct packed {
        logic             rx_dma_en;
        logic [LVL_W-1:0] af_lvl;
        logic             tx_dma_en;
        logic [LVL_W-1:0] ae_lvl;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{rx_dma_en: 1'b0, af_lvl: '1,
                                   tx_dma_en: 1'b0, ae_lvl: '0};

    function automatic cfg_t cfg_unpack(input logic [WORD_W-1:0] w);
        cfg_t c;
        c.rx_dma_en = w[RX_EN_BIT];
        c.af_lvl    = w[AF_LSB +: LVL_W];
        c.tx_dma_en = w[TX_EN_BIT];
        c.ae_lvl    = w[AE_LSB +: LVL_W];
        return c;
    endfunction

endpackage

// File: rtl/dbuf_cfg_reg.sv
module dbuf_cfg_reg
    import dbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output cfg_t              cfg
);

    cfg_t cfg_d, cfg_q;

    // Bits outside the four fields carry no meaning
    logic unused_rsvd;
    assign unused_rsvd = &{1'b0, wdata[14:13], wdata[6:5]};

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d = cfg_unpack(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

    // R9: a write lands in the register on the next cycle
    a_r9_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cfg_q.rx_dma_en == $past(wdata[RX_EN_BIT]) &&
                cfg_q.af_lvl == $past(wdata[AF_LSB +: LVL_W])));

endmodule

// File: rtl/dbuf_store.sv
module dbuf_store #(
    parameter int DW    = 16,
    parameter int DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DW-1:0]     wdata,
    input  logic              pop,
    output logic [DW-1:0]     rdata,
    output logic [CNT_W-1:0]  count
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W:0]   WRAP     = (PTR_W+1)'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];

    logic           do_push, do_pop;
    logic [PTR_W:0] tail_sum, head_inc;
    logic [PTR_W-1:0] tail_idx;

    always_comb begin
        do_push  = push && (st_q.cnt != FULL_CNT) && !flush;
        do_pop   = pop && (st_q.cnt != '0) && !flush;

        tail_sum = {1'b0, st_q.head} + (PTR_W+1)'(st_q.cnt);
        if (tail_sum >= WRAP) begin
            tail_sum = tail_sum - WRAP;
        end
        tail_idx = tail_sum[PTR_W-1:0];

        head_inc = {1'b0, st_q.head} + 1'b1;
        if (head_inc >= WRAP) begin
            head_inc = '0;
        end

        st_d = st_q;
        if (flush) begin
            st_d.head = '0;
            st_d.cnt  = '0;
        end else begin
            if (do_pop) begin
                st_d.head = head_inc[PTR_W-1:0];
            end
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[tail_idx] <= wdata;
        end
    end

    assign rdata = mem_q[st_q.head];
    assign count = st_q.cnt;

    a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_CNT);

    a_r3_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == FULL_CNT && push && !pop && !flush) |=> st_q.cnt == FULL_CNT);

    a_r4_empty_pop_still: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0 && pop && !push && !flush) |=>
            (st_q.cnt == '0 && $stable(st_q.head)));

    a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.cnt == '0 && st_q.head == '0));

endmodule

// File: rtl/dbuf_level_eval.sv
module dbuf_level_eval
    import dbuf_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic [CNT_W-1:0] count,
    input  cfg_t             cfg,
    input  logic             xfer_active,
    input  logic             xfer_dir,
    output logic             rx_req,
    output logic             tx_req,
    output logic             af_flag,
    output logic             ae_flag
);

    logic quiet, over_af, under_ae;

    always_comb begin
        quiet    = !xfer_active && (count == '0);
        over_af  = !quiet &&  xfer_dir && (count > CNT_W'(cfg.af_lvl));
        under_ae = !quiet && !xfer_dir && (count < CNT_W'(cfg.ae_lvl));

        rx_req  = over_af  &&  cfg.rx_dma_en;
        af_flag = over_af  && !cfg.rx_dma_en;
        tx_req  = under_ae &&  cfg.tx_dma_en;
        ae_flag = under_ae && !cfg.tx_dma_en;
    end

endmodule

// File: rtl/dbuf_thresh_fifo.sv
module dbuf_thresh_fifo
    import dbuf_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic        xfer_active,
    input  logic        xfer_dir,
    input  logic        cfg_we,
    input  logic [15:0] cfg_wdata,
    input  logic        host_push,
    input  logic [15:0] host_wdata,
    input  logic        host_pop,
    output logic [15:0] host_rdata,
    input  logic        eng_push,
    input  logic [15:0] eng_wdata,
    input  logic        eng_pop,
    output logic [15:0] eng_rdata,
    output logic [5:0]  fill_level,
    output logic        rx_dma_req,
    output logic        tx_dma_req,
    output logic        flag_af,
    output logic        flag_ae
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    cfg_t              cfg;
    logic              any_push, any_pop;
    logic [WORD_W-1:0] push_word, head_word;
    logic [CNT_W-1:0]  level;

    // Host side wins when both sides push together
    always_comb begin
        any_push  = host_push || eng_push;
        any_pop   = host_pop || eng_pop;
        push_word = host_push ? host_wdata : eng_wdata;
    end

    dbuf_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    dbuf_store #(.DW(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (any_push),
        .wdata (push_word),
        .pop   (any_pop),
        .rdata (head_word),
        .count (level)
    );

    dbuf_level_eval #(.CNT_W(CNT_W)) u_eval (
        .count       (level),
        .cfg         (cfg),
        .xfer_active (xfer_active),
        .xfer_dir    (xfer_dir),
        .rx_req      (rx_dma_req),
        .tx_req      (tx_dma_req),
        .af_flag     (flag_af),
        .ae_flag     (flag_ae)
    );

    assign host_rdata = head_word;
    assign eng_rdata  = head_word;
    assign fill_level = 6'(level);

    a_r6_rx_req_or_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_dma_req && flag_af));

    a_r7_tx_req_or_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_dma_req && flag_ae));

    a_r8_idle_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_active && fill_level == '0) |->
            !(rx_dma_req || tx_dma_req || flag_af || flag_ae));

    a_r10_rx_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[RX_EN_BIT]) |=> !flag_af);

    a_r10_tx_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[TX_EN_BIT]) |=> !flag_ae);

    a_r12_push_pop_level: assert property (@(posedge clk) disable iff (!rst_n)
        (any_push && any_pop && !flush && fill_level != '0 &&
         fill_level != 6'(DEPTH)) |=> $stable(fill_level));

endmodule

// File: tb/sim_dbuf_thresh_fifo.sv
module sim_dbuf_thresh_fifo;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0, xfer_active = 1'b0, xfer_dir = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        host_push = 1'b0, host_pop = 1'b0, eng_push = 1'b0, eng_pop = 1'b0;
    logic [15:0] host_wdata = '0, eng_wdata = '0;
    logic [15:0] host_rdata, eng_rdata;
    logic [5:0]  fill_level;
    logic        rx_dma_req, tx_dma_req, flag_af, flag_ae;

    dbuf_thresh_fifo u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .xfer_active(xfer_active), .xfer_dir(xfer_dir),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .host_push(host_push), .host_wdata(host_wdata),
        .host_pop(host_pop), .host_rdata(host_rdata),
        .eng_push(eng_push), .eng_wdata(eng_wdata),
        .eng_pop(eng_pop), .eng_rdata(eng_rdata),
        .fill_level(fill_level),
        .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
        .flag_af(flag_af), .flag_ae(flag_ae)
    );

    always #2 clk = ~clk;

    int    checks = 0, errors = 0, cyc_n = 0;
    string cur_tag = "R1";
    bit    done = 0;

    // Behavioural reference
    logic [15:0] mq[$];
    logic [15:0] hist[32];
    bit          hv[32];
    int          rd_slot = 0;
    bit          m_rxen = 0, m_txen = 0;
    int          m_af = 31, m_ae = 0;

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin : model
        bit pu, po;
        logic [15:0] d;
        int sz, wr;
        if (!rst_n) begin
            mq.delete();
            rd_slot = 0;
            m_rxen = 0; m_txen = 0; m_af = 31; m_ae = 0;
            foreach (hv[k]) hv[k] = 0;
        end else begin
            if (flush) begin
                mq.delete();
                rd_slot = 0;
            end else begin
                sz = mq.size();
                pu = (host_push || eng_push) && sz < 32;
                po = (host_pop || eng_pop) && sz > 0;
                d  = host_push ? host_wdata : eng_wdata;
                wr = (rd_slot + sz) % 32;
                if (po) begin
                    void'(mq.pop_front());
                    rd_slot = (rd_slot + 1) % 32;
                end
                if (pu) begin
                    mq.push_back(d);
                    hist[wr] = d;
                    hv[wr] = 1;
                end
            end
            if (cfg_we) begin
                m_rxen = cfg_wdata[15];
                m_af   = int'(cfg_wdata[12:8]);
                m_txen = cfg_wdata[7];
                m_ae   = int'(cfg_wdata[4:0]);
            end
        end
    end

    always @(negedge clk) begin : compare
        int n;
        bit quiet, rc, tc;
        if (rst_n && !done) begin
            n     = mq.size();
            quiet = !xfer_active && n == 0;
            rc    = !quiet && xfer_dir && n > m_af;
            tc    = !quiet && !xfer_dir && n < m_ae;
            chk(cur_tag, "level", 16'(fill_level), 16'(n));
            chk(cur_tag, "rx_dma_req", 16'(rx_dma_req), 16'(rc && m_rxen));
            chk(cur_tag, "flag_af", 16'(flag_af), 16'(rc && !m_rxen));
            chk(cur_tag, "tx_dma_req", 16'(tx_dma_req), 16'(tc && m_txen));
            chk(cur_tag, "flag_ae", 16'(flag_ae), 16'(tc && !m_txen));
            if (hv[rd_slot]) begin
                chk(cur_tag, "host_rdata", host_rdata, hist[rd_slot]);
                chk("R5", "eng_rdata", eng_rdata, hist[rd_slot]);
            end
        end
    end

    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n == 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual %0d expected below %0d", cyc_n, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask
    task automatic eng_wr(logic [15:0] d);
        eng_push = 1; eng_wdata = d; tick(); eng_push = 0;
    endtask
    task automatic host_wr(logic [15:0] d);
        host_push = 1; host_wdata = d; tick(); host_push = 0;
    endtask
    task automatic host_rd();
        host_pop = 1; tick(); host_pop = 0;
    endtask
    task automatic set_cfg(logic [15:0] w);
        cfg_we = 1; cfg_wdata = w; tick(); cfg_we = 0;
    endtask
    task automatic do_flush();
        flush = 1; tick(); flush = 0;
    endtask

    logic [15:0] lf = 16'hACE1;

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1: reset state
        cur_tag = "R1";
        chk("R1", "level after reset", 16'(fill_level), 16'd0);
        chk("R1", "flags after reset", 16'({rx_dma_req, tx_dma_req, flag_af, flag_ae}), 16'd0);
        xfer_active = 1; xfer_dir = 1;
        tick();
        // R2 fill from engine; default almost-full of 31 trips at 32
        cur_tag = "R2";
        for (int i = 0; i < 32; i++) eng_wr(16'hA000 + 16'(i));
        chk("R1", "flag_af at 32 with default level", 16'(flag_af), 16'd1);
        cur_tag = "R3";
        eng_wr(16'hDEAD);
        chk("R3", "level after push on full", 16'(fill_level), 16'd32);
        cur_tag = "R2";
        for (int i = 0; i < 32; i++) begin
            chk("R2", "pop order", host_rdata, 16'hA000 + 16'(i));
            host_rd();
        end
        cur_tag = "R4";
        host_rd();
        chk("R4", "level after empty pop", 16'(fill_level), 16'd0);
        chk("R4", "head word after empty pop", host_rdata, 16'hA000);
        host_wr(16'h1234);
        chk("R4", "next push lands at head", host_rdata, 16'h1234);
        // R9 / R6: junk bits set, rx DMA on, almost-full 4
        cur_tag = "R9";
        do_flush();
        set_cfg(16'h8000 | 16'h0400 | 16'h6060);
        cur_tag = "R6";
        for (int i = 0; i < 5; i++) eng_wr(16'hB000 + 16'(i));
        chk("R6", "rx_dma_req above level 4", 16'(rx_dma_req), 16'd1);
        set_cfg(16'h0400);
        chk("R6", "flag_af with rx DMA off", 16'(flag_af), 16'd1);
        cur_tag = "R10";
        set_cfg(16'h8400);
        chk("R10", "flag_af cleared by enable", 16'(flag_af), 16'd0);
        // R7: host to card, almost-empty 8
        cur_tag = "R7";
        do_flush();
        xfer_dir = 0;
        set_cfg(16'h0008);
        chk("R7", "flag_ae when empty and active", 16'(flag_ae), 16'd1);
        for (int i = 0; i < 8; i++) host_wr(16'hC000 + 16'(i));
        chk("R7", "flag_ae off at level 8", 16'(flag_ae), 16'd0);
        set_cfg(16'h0088);
        eng_pop = 1; tick(); tick(); eng_pop = 0;
        chk("R7", "tx_dma_req at level 6", 16'(tx_dma_req), 16'd1);
        // R8: idle behaviour
        cur_tag = "R8";
        set_cfg(16'h0008);
        do_flush();
        xfer_active = 0;
        tick();
        chk("R8", "idle empty quiet", 16'({rx_dma_req, tx_dma_req, flag_af, flag_ae}), 16'd0);
        host_wr(16'h5555);
        chk("R8", "idle non-empty still evaluated", 16'(flag_ae), 16'd1);
        // R12: simultaneous pushes, push with pop
        cur_tag = "R12";
        host_push = 1; eng_push = 1; host_wdata = 16'h1111; eng_wdata = 16'h2222;
        tick();
        host_push = 0; eng_push = 0;
        chk("R12", "one word from dual push", 16'(fill_level), 16'd2);
        host_rd();
        chk("R12", "host word stored", host_rdata, 16'h1111);
        eng_push = 1; eng_wdata = 16'h3333; host_pop = 1;
        tick();
        eng_push = 0; host_pop = 0;
        chk("R12", "push with pop keeps level", 16'(fill_level), 16'd1);
        // R11: flush with simultaneous push
        cur_tag = "R11";
        flush = 1; host_push = 1; host_wdata = 16'h7777;
        tick();
        flush = 0; host_push = 0;
        chk("R11", "flush drops same-cycle push", 16'(fill_level), 16'd0);
        // R13: mixed pseudo-random traffic, compared each cycle
        cur_tag = "R13";
        xfer_active = 1;
        for (int i = 0; i < 4000; i++) begin
            host_push  = lf[0] & lf[1];
            eng_push   = lf[2] & lf[3];
            host_pop   = lf[4] & lf[5];
            eng_pop    = lf[6] & lf[7] & lf[8];
            host_wdata = {lf[7:0], lf[15:8]};
            eng_wdata  = lf ^ 16'h5A5A;
            if (lf[12:9] == 4'd0) xfer_dir = ~xfer_dir;
            if (lf[11:10] == 2'd0 && lf[14]) xfer_active = ~xfer_active;
            cfg_we     = (lf[15:13] == 3'd0);
            cfg_wdata  = {lf[3], lf[10:0], lf[15:12]};
            flush      = (lf[15:9] == 7'd0);
            tick();
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        end
        host_push = 0; eng_push = 0; host_pop = 0; eng_pop = 0;
        cfg_we = 0; flush = 0;
        tick();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule